// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Generator

This block produces an active-low system reset when an operator holds two push-buttons down together for a long time. Both button inputs arrive already synchronized to the block clock and are active-low (0 = pressed). A free-running prescaler derived from a clock-frequency parameter gives a slow tick, and all delays are counted in those ticks. While both buttons are pressed the hold timer advances. Releasing either one sends the timer back to zero. When the hold time has passed, the reset output goes low.

A build parameter picks how the reset ends. In fixed mode it lasts a set pulse length. After that the block waits until the buttons have been released and pressed again. In latched mode the reset stays low until either button is released. A select input, captured when power-good rises, picks a short or a long hold time. Another build parameter can turn the long setting into a near-zero detection delay for factory test. A single-button build ignores the second input. A power-good input stands in for the supply monitor: while it is low the reset is held asserted and every counter is cleared. After it rises, a start-up delay must pass before the block looks at the buttons.

The block has no data stream. All pins are plain control levels with no handshake.

Top module: `long_press_reset`

## Requirements
- R1: While `pg_i` is 0 the output `rst_no` is 0 (reset asserted) from the next clock on, and every timer is cleared. A press that was partly timed before a power-good drop therefore starts again from zero. `rst_no` is also 0 while `arst_ni` is 0.
- R2: The hold timer advances only while both button inputs are 0 (pressed). If either input goes to 1, the timer restarts from zero.
- R3: With the captured select at 0, `rst_no` falls after both buttons have been pressed for HOLD_LO_MS.
- R4: With the captured select at 1 and ZERO_HOLD = 0, `rst_no` falls after both buttons have been pressed for HOLD_HI_MS.
- R5: With the captured select at 1 and ZERO_HOLD = 1, `rst_no` falls after a press of DETECT_US (rounded to whole ticks, at least one).
- R6: With LATCHED = 0, `rst_no` stays 0 for PULSE_MS and then returns to 1 by itself.
- R7: With LATCHED = 1, `rst_no` stays 0 for as long as both buttons remain pressed, and returns to 1 within two clocks of either button going to 1.
- R8: After `pg_i` rises, the buttons are ignored for STARTUP_US. Buttons already held at that edge start the hold timer only once that delay has ended.
- R9: With SINGLE = 1, `btn_b_ni` is ignored, and a press of `btn_a_ni` alone controls the hold timer.
- R10: With LATCHED = 0, once a fixed pulse has ended, no further reset occurs until both buttons have gone to 1 and have then been pressed again.
- R11: `sel_long_i` is captured while `pg_i` is 0 and at its rising edge. Changes after that have no effect until the next power-good cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, CLK_HZ |
| arst_ni | input | 1 | Asynchronous active-low chip reset |
| pg_i | input | 1 | Power-good, 1 = supply valid |
| btn_a_ni | input | 1 | First button, synchronized, 0 = pressed |
| btn_b_ni | input | 1 | Second button, synchronized, 0 = pressed |
| sel_long_i | input | 1 | Hold-time select, captured at power-good rise |
| rst_no | output | 1 | Reset output, 0 = asserted |

## Verification
The bench builds three copies with a 100 kHz nominal clock and a 10 kHz tick, so the prescaler divides by ten. Hold times are set to 5 ms and 8 ms, the pulse to 2 ms, detection to 300 µs and start-up to 500 µs. These scaled values make every window a few hundred cycles long, so the hold restart, pulse release, re-arm and start-up ordering are all reached in a short run. One copy is fixed-pulse, one is latched, and one is a single-button build with the zero-hold setting. Together they cover every mode parameter and the detection-delay path.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_START = 3'd1,
    ST_IDLE  = 3'd2,
    ST_RST   = 3'd3,
    ST_WAIT  = 3'd4
  } lpr_state_e;

  function automatic int unsigned at_least_one(input longint unsigned v);
    return (v == 0) ? 1 : int'(v);
  endfunction
endpackage

// File: rtl/lpr_prescaler.sv
module lpr_prescaler #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = ~clr_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni)          cnt_q <= '0;
        else if (clr_i)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = ~clr_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/lpr_span_counter.sv
module lpr_span_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] target_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)                         cnt_q <= '0;
    else if (!run_i)                      cnt_q <= '0;
    else if (tick_i && cnt_q < target_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q >= target_i);
endmodule

// File: rtl/lpr_fsm.sv
module lpr_fsm
  import lpr_pkg::*;
#(
  parameter bit LATCHED = 1'b0
) (
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic       pg_i,
  input  logic       both_low_i,
  input  logic       both_high_i,
  input  logic       start_done_i,
  input  logic       hold_done_i,
  input  logic       pulse_done_i,
  output lpr_state_e state_o
);
  lpr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   state_d = ST_START;
      ST_START: if (start_done_i) state_d = ST_IDLE;
      ST_IDLE:  if (hold_done_i)  state_d = ST_RST;
      ST_RST: begin
        if (LATCHED) begin
          if (!both_low_i) state_d = ST_IDLE;
        end else if (pulse_done_i) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT:  if (both_high_i)  state_d = ST_IDLE;
      default:  state_d = ST_OFF;
    endcase
    if (!pg_i) state_d = ST_OFF;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) state_q <= ST_OFF;
    else          state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/long_press_reset.sv
module long_press_reset
  import lpr_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 1_000_000,
  parameter int unsigned TICK_HZ    = 10_000,
  parameter int unsigned HOLD_LO_MS = 7500,
  parameter int unsigned HOLD_HI_MS = 12500,
  parameter int unsigned PULSE_MS   = 400,
  parameter int unsigned DETECT_US  = 150,
  parameter int unsigned STARTUP_US = 300,
  parameter bit          ZERO_HOLD  = 1'b0,
  parameter bit          LATCHED    = 1'b0,
  parameter bit          SINGLE     = 1'b0
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic pg_i,
  input  logic btn_a_ni,
  input  logic btn_b_ni,
  input  logic sel_long_i,
  output logic rst_no
);
  localparam int unsigned DIV       = at_least_one(longint'(CLK_HZ) / longint'(TICK_HZ));
  localparam int unsigned HOLD_LO_T = at_least_one(longint'(HOLD_LO_MS) * TICK_HZ / 1000);
  localparam int unsigned HOLD_HI_T = at_least_one(longint'(HOLD_HI_MS) * TICK_HZ / 1000);
  localparam int unsigned PULSE_T   = at_least_one(longint'(PULSE_MS) * TICK_HZ / 1000);
  localparam int unsigned DETECT_T  = at_least_one(longint'(DETECT_US) * TICK_HZ / 1_000_000);
  localparam int unsigned START_T   = at_least_one(longint'(STARTUP_US) * TICK_HZ / 1_000_000);
  localparam int unsigned SEL_HI_T  = ZERO_HOLD ? DETECT_T : HOLD_HI_T;
  localparam int unsigned MAX_A     = (HOLD_LO_T > SEL_HI_T) ? HOLD_LO_T : SEL_HI_T;
  localparam int unsigned MAX_B     = (PULSE_T > START_T) ? PULSE_T : START_T;
  localparam int unsigned MAX_T     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW        = $clog2(MAX_T + 1);
  localparam int unsigned PULSE_CYC = PULSE_T * DIV;

  lpr_state_e state_q;
  logic       tick;
  logic       both_low, both_high;
  logic       sel_q;
  logic       start_done, hold_done, pulse_done;
  logic [CW-1:0] hold_target;

  generate
    if (SINGLE) begin : g_one
      assign both_low  = ~btn_a_ni;
      assign both_high = btn_a_ni;
    end else begin : g_two
      assign both_low  = ~btn_a_ni & ~btn_b_ni;
      assign both_high = btn_a_ni & btn_b_ni;
    end
  endgenerate

  // select is followed while in the power-off state, frozen afterwards
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)               sel_q <= 1'b0;
    else if (state_q == ST_OFF) sel_q <= sel_long_i;
  end

  assign hold_target = sel_q ? CW'(SEL_HI_T) : CW'(HOLD_LO_T);

  lpr_prescaler #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .clr_i  (~pg_i),
    .tick_o (tick)
  );

  lpr_span_counter #(.W(CW)) u_start (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .run_i   (state_q == ST_START),
    .tick_i  (tick),
    .target_i(CW'(START_T)),
    .done_o  (start_done)
  );

  lpr_span_counter #(.W(CW)) u_hold (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .run_i   ((state_q == ST_IDLE) && both_low),
    .tick_i  (tick),
    .target_i(hold_target),
    .done_o  (hold_done)
  );

  lpr_span_counter #(.W(CW)) u_pulse (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .run_i   ((state_q == ST_RST) && !LATCHED),
    .tick_i  (tick),
    .target_i(CW'(PULSE_T)),
    .done_o  (pulse_done)
  );

  lpr_fsm #(.LATCHED(LATCHED)) u_fsm (
    .clk_i       (clk_i),
    .arst_ni     (arst_ni),
    .pg_i        (pg_i),
    .both_low_i  (both_low),
    .both_high_i (both_high),
    .start_done_i(start_done),
    .hold_done_i (hold_done),
    .pulse_done_i(pulse_done),
    .state_o     (state_q)
  );

  assign rst_no = !((state_q == ST_OFF) || (state_q == ST_RST));
endmodule

// File: rtl/lpr_checker.sv
module lpr_checker
  import lpr_pkg::*;
#(
  parameter bit          LATCHED   = 1'b0,
  parameter bit          SINGLE    = 1'b0,
  parameter int unsigned PULSE_CYC = 1000
) (
  input logic       clk_i,
  input logic       arst_ni,
  input logic       pg_i,
  input logic       btn_a_ni,
  input logic       btn_b_ni,
  input logic       rst_no,
  input logic       sel_q,
  input lpr_state_e state_q
);
  logic pressed, released;
  int unsigned low_cycles;

  assign pressed  = !btn_a_ni && (SINGLE || !btn_b_ni);
  assign released = btn_a_ni && (SINGLE || btn_b_ni);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)               low_cycles <= 0;
    else if (state_q == ST_RST) low_cycles <= low_cycles + 1;
    else                        low_cycles <= 0;
  end

  assert_pwr_hold_R1: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !pg_i |=> !rst_no);

  // R2: a reset starts only after a held press, or because power went away
  assert_press_cause_R2: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(rst_no) |-> ($past(!pg_i) || $past(pressed)));

  assert_pulse_len_R6: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (!LATCHED && state_q == ST_RST) |-> (low_cycles <= PULSE_CYC));

  assert_latch_hold_R7: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (LATCHED && state_q == ST_RST && pg_i && pressed) |=> !rst_no);

  assert_no_retrigger_R10: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (state_q == ST_WAIT && pg_i && !released) |=> rst_no);

  assert_sel_frozen_R11: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (state_q != ST_OFF && pg_i) |=> $stable(sel_q));
endmodule

bind long_press_reset lpr_checker #(
  .LATCHED  (LATCHED),
  .SINGLE   (SINGLE),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk_i   (clk_i),
  .arst_ni (arst_ni),
  .pg_i    (pg_i),
  .btn_a_ni(btn_a_ni),
  .btn_b_ni(btn_b_ni),
  .rst_no  (rst_no),
  .sel_q   (sel_q),
  .state_q (state_q)
);

// File: tb/sim_long_press_reset.sv
module sim_long_press_reset;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic pg = 1'b0;
  logic a_n = 1'b1;
  logic b_n = 1'b1;
  logic sel = 1'b0;
  logic rst0, rst1, rst2;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  long_press_reset #(.CLK_HZ(100_000), .TICK_HZ(10_000), .HOLD_LO_MS(5), .HOLD_HI_MS(8),
    .PULSE_MS(2), .DETECT_US(300), .STARTUP_US(500), .ZERO_HOLD(1'b0), .LATCHED(1'b0),
    .SINGLE(1'b0)) u0 (.clk_i(clk), .arst_ni(arst_n), .pg_i(pg), .btn_a_ni(a_n),
    .btn_b_ni(b_n), .sel_long_i(sel), .rst_no(rst0));

  long_press_reset #(.CLK_HZ(100_000), .TICK_HZ(10_000), .HOLD_LO_MS(5), .HOLD_HI_MS(8),
    .PULSE_MS(2), .DETECT_US(300), .STARTUP_US(500), .ZERO_HOLD(1'b0), .LATCHED(1'b1),
    .SINGLE(1'b0)) u1 (.clk_i(clk), .arst_ni(arst_n), .pg_i(pg), .btn_a_ni(a_n),
    .btn_b_ni(b_n), .sel_long_i(sel), .rst_no(rst1));

  long_press_reset #(.CLK_HZ(100_000), .TICK_HZ(10_000), .HOLD_LO_MS(5), .HOLD_HI_MS(8),
    .PULSE_MS(2), .DETECT_US(300), .STARTUP_US(500), .ZERO_HOLD(1'b1), .LATCHED(1'b0),
    .SINGLE(1'b1)) u2 (.clk_i(clk), .arst_ni(arst_n), .pg_i(pg), .btn_a_ni(a_n),
    .btn_b_ni(b_n), .sel_long_i(sel), .rst_no(rst2));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up(input logic s);
    pg = 1'b0;
    cyc(5);
    sel = s;
    cyc(1);
    pg = 1'b1;
    cyc(80);
  endtask

  task automatic settle();
    a_n = 1'b1;
    b_n = 1'b1;
    cyc(300);
  endtask

  task automatic t_reset();
    cyc(1);
    chk(rst0, 1'b0, "R1 output during chip reset");
    arst_n = 1'b1;
    cyc(3);
    chk(rst0, 1'b0, "R1 output with power-good low");
  endtask

  task automatic t_hold_lo();
    power_up(1'b0);
    a_n = 1'b0; b_n = 1'b0;
    cyc(470);
    chk(rst0, 1'b1, "R3 before short hold ends");
    cyc(50);
    chk(rst0, 1'b0, "R3 after short hold");
    cyc(150);
    chk(rst0, 1'b0, "R6 inside pulse");
    cyc(50);
    chk(rst0, 1'b1, "R6 pulse self-release");
    cyc(700);
    chk(rst0, 1'b1, "R10 held press does not retrigger");
    a_n = 1'b1; b_n = 1'b1;
    cyc(20);
    a_n = 1'b0; b_n = 1'b0;
    cyc(530);
    chk(rst0, 1'b0, "R10 new press after release");
    settle();
  endtask

  task automatic t_restart();
    power_up(1'b0);
    a_n = 1'b0; b_n = 1'b0;
    cyc(300);
    b_n = 1'b1;
    cyc(5);
    b_n = 1'b0;
    cyc(300);
    chk(rst0, 1'b1, "R2 timer restarted after release");
    cyc(220);
    chk(rst0, 1'b0, "R2 full hold after re-press");
    settle();
  endtask

  task automatic t_hold_hi();
    power_up(1'b1);
    sel = 1'b0;
    a_n = 1'b0; b_n = 1'b0;
    cyc(530);
    chk(rst0, 1'b1, "R11 select change after power-up ignored");
    cyc(240);
    chk(rst0, 1'b1, "R4 before long hold ends");
    cyc(50);
    chk(rst0, 1'b0, "R4 after long hold");
    settle();
  endtask

  task automatic t_latched();
    power_up(1'b0);
    a_n = 1'b0; b_n = 1'b0;
    cyc(520);
    chk(rst1, 1'b0, "R7 latched reset asserted");
    cyc(600);
    chk(rst1, 1'b0, "R7 latched reset held past pulse length");
    a_n = 1'b1;
    cyc(3);
    chk(rst1, 1'b1, "R7 latched reset ends on release");
    settle();
  endtask

  task automatic t_startup();
    pg = 1'b0;
    sel = 1'b1;
    a_n = 1'b0; b_n = 1'b0;
    cyc(5);
    pg = 1'b1;
    cyc(40);
    chk(rst0, 1'b1, "R8 no reset during start-up (u0)");
    chk(rst2, 1'b1, "R8 no reset during start-up (u2)");
    cyc(25);
    chk(rst2, 1'b1, "R8 detection waits for start-up end");
    cyc(35);
    chk(rst2, 1'b0, "R5 zero-hold reset after start-up");
    settle();
  endtask

  task automatic t_single();
    power_up(1'b1);
    a_n = 1'b0; b_n = 1'b1;
    cyc(15);
    chk(rst2, 1'b1, "R5 detection delay not instant");
    cyc(30);
    chk(rst2, 1'b0, "R9 single button triggers");
    chk(rst0, 1'b1, "R9 dual build needs both buttons");
    settle();
  endtask

  task automatic t_pg_drop();
    power_up(1'b0);
    a_n = 1'b0; b_n = 1'b0;
    cyc(200);
    pg = 1'b0;
    cyc(2);
    chk(rst0, 1'b0, "R1 power-good drop asserts reset (u0)");
    chk(rst1, 1'b0, "R1 power-good drop asserts reset (u1)");
    chk(rst2, 1'b0, "R1 power-good drop asserts reset (u2)");
    pg = 1'b1;
    cyc(450);
    chk(rst0, 1'b1, "R1 timers cleared by power-good drop");
    cyc(150);
    chk(rst0, 1'b0, "R8 held press timed after start-up");
    settle();
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt >= 100_000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_hold_lo();
    t_restart();
    t_hold_hi();
    t_latched();
    t_startup();
    t_single();
    t_pg_drop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule